// File: doc/BRIEF.md
# Fusable Two-Channel Pulse-Width Modulator

This block contains two neighbouring pulse-width modulator channels, an even one and an odd one, that share a register port. Each channel has a period value, a duty value, a counter, an enable, a polarity select, a choice between two clock enables, and a choice between edge-aligned and center-aligned counting. Each channel drives its own output pin.

A single fuse bit changes how the pair is used. When the bit is clear, the channels run as two independent narrow modulators. When the bit is set, they act as one modulator of twice the width. The even channel's period, duty and counter supply the upper byte, and the odd channel's supply the lower byte. The odd channel's control bits govern the fused waveform, and the waveform appears on the odd pin. The even pin then rests at its inactive level.

Period and duty writes land in buffers. The buffered values take effect at the next period boundary, or at once while the channel is idle. A build parameter can remove the fuse capability. In that build, the fuse bit ignores writes and reads as zero.

Top module: `pwm_pair`

## Requirements
- R1: Register port, with 3-bit address and combinational read data. Address 0 is the control byte:
  - bit0 enables the even channel and bit1 enables the odd channel.
  - bit2 and bit3 are the even and odd polarity.
  - bit4 and bit5 are the even and odd clock select.
  - bit6 and bit7 are the even and odd center mode.

  Address 1 bit0 is the fuse bit. Addresses 2 and 3 are the even and odd period, and addresses 4 and 5 are the even and odd duty. All of these read back the last value written. Addresses 6 and 7 read the even and odd counters. Everything resets to zero.
- R2: In edge-aligned mode (center bit 0), an enabled channel's counter steps 0,1,…,period−1 on each selected clock enable and then returns to 0. The output is at its active level while the counter is below duty.
- R3: In center-aligned mode (center bit 1), the counter steps up from 0 to period and back down to 1 before restarting at 0, so one cycle takes 2×period enables. The output is active while the counter is below duty.
- R4: Polarity 1 makes the active level high and polarity 0 makes it low. A disabled channel's pin sits at the inactive level, which is the inverse of its polarity bit.
- R5: Clock select 0 advances the counter on `tick_a` and clock select 1 advances it on `tick_b`. The other enable has no effect on the counter.
- R6: Period and duty writes made while a channel runs take effect only when its counter returns to 0 at the end of a cycle. While the channel is disabled they take effect at once.
- R7: Clearing a channel's enable returns its counter to 0.
- R8: With the fuse bit set, the pair forms one 16-bit channel. Its period is {even period, odd period}, its duty is {even duty, odd duty}, and its waveform appears on `pwm_odd`. The even counter address reads the counter's upper byte and the odd counter address reads the lower byte.
- R9: With the fuse bit set, the odd channel's enable, polarity, clock select and center bits govern the fused channel. The even channel's enable, clock select and center bits have no effect. `pwm_even` stays at the inverse of the even polarity bit.
- R10: When parameter `PAIR_PRESENT` is 0, the fuse bit ignores writes and reads 0, and the channels stay independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CH_W | Write data |
| reg_rdata | output | CH_W | Read data for `reg_addr` |
| tick_a | input | 1 | First prescaled clock enable |
| tick_b | input | 1 | Second prescaled clock enable |
| pwm_even | output | 1 | Even channel output pin |
| pwm_odd | output | 1 | Odd channel output pin, carries the fused waveform |

## Verification
The counter-range assertions assume the following about the block's inputs:
- The fuse bit changes only while both enables are clear.
- A channel's center bit does not change while that channel is enabled.

Without these conditions, a counter left above a new period could break the bounds. The stimulus keeps to them: every trial first writes a control byte with both enables clear, then sets the fuse bit, the buffers and the mode bits, and only then turns the enables on. Within a trial, only period and duty change while the channels run. Clock enables are random single-cycle pulses on either input, both, or neither, and are never issued in the same cycle as a register write.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADR_W-1:0] ADR_FUSE   = 3'd1;
  localparam logic [ADR_W-1:0] ADR_PER_E  = 3'd2;
  localparam logic [ADR_W-1:0] ADR_PER_O  = 3'd3;
  localparam logic [ADR_W-1:0] ADR_DUTY_E = 3'd4;
  localparam logic [ADR_W-1:0] ADR_DUTY_O = 3'd5;
  localparam logic [ADR_W-1:0] ADR_CNT_E  = 3'd6;
  localparam logic [ADR_W-1:0] ADR_CNT_O  = 3'd7;

  // Control byte, MSB first; bit0 is the even enable.
  typedef struct packed {
    logic ctr_o;
    logic ctr_e;
    logic sel_o;
    logic sel_e;
    logic pol_o;
    logic pol_e;
    logic en_o;
    logic en_e;
  } ctrl_t;

  // Pin level for a channel: active level equals the polarity bit.
  function automatic logic pin_level(input logic active, input logic pol_hi);
    return active ? pol_hi : ~pol_hi;
  endfunction

  // Picks the clock enable named by a select bit.
  function automatic logic pick_tick(input logic sel, input logic ta, input logic tb);
    return sel ? tb : ta;
  endfunction

endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
  import pwm_pair_pkg::*;
#(
  parameter int CH_W         = 8,
  parameter bit PAIR_PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ADR_W-1:0] addr,
  input  logic [CH_W-1:0]  wdata,
  input  logic [CH_W-1:0]  cnt_e_rd,
  input  logic [CH_W-1:0]  cnt_o_rd,
  output logic [CH_W-1:0]  rdata,
  output ctrl_t            ctrl,
  output logic             fuse,
  output logic [CH_W-1:0]  per_e,
  output logic [CH_W-1:0]  per_o,
  output logic [CH_W-1:0]  duty_e,
  output logic [CH_W-1:0]  duty_o
);

  localparam int CTRL_W = $bits(ctrl_t);

  logic wr_ctrl, wr_fuse, wr_per_e, wr_per_o, wr_duty_e, wr_duty_o;

  assign wr_ctrl   = wr && (addr == ADR_CTRL);
  assign wr_fuse   = wr && (addr == ADR_FUSE);
  assign wr_per_e  = wr && (addr == ADR_PER_E);
  assign wr_per_o  = wr && (addr == ADR_PER_O);
  assign wr_duty_e = wr && (addr == ADR_DUTY_E);
  assign wr_duty_o = wr && (addr == ADR_DUTY_O);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      per_e  <= '0;
      per_o  <= '0;
      duty_e <= '0;
      duty_o <= '0;
    end else begin
      if (wr_ctrl)   ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_per_e)  per_e  <= wdata;
      if (wr_per_o)  per_o  <= wdata;
      if (wr_duty_e) duty_e <= wdata;
      if (wr_duty_o) duty_o <= wdata;
    end
  end

  generate
    if (PAIR_PRESENT) begin : g_fuse
      logic fuse_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       fuse_q <= 1'b0;
        else if (wr_fuse) fuse_q <= wdata[0];
      end
      assign fuse = fuse_q;
    end else begin : g_nofuse
      assign fuse = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (addr)
      ADR_CTRL:   rdata = CH_W'(ctrl);
      ADR_FUSE:   rdata = CH_W'(fuse);
      ADR_PER_E:  rdata = per_e;
      ADR_PER_O:  rdata = per_o;
      ADR_DUTY_E: rdata = duty_e;
      ADR_DUTY_O: rdata = duty_o;
      ADR_CNT_E:  rdata = cnt_e_rd;
      default:    rdata = cnt_o_rd;
    endcase
  end

  AST_PER_BUF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_per_e |=> per_e == $past(wdata)); // R1

  AST_DUTY_BUF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_duty_o |=> duty_o == $past(wdata)); // R1

endmodule

// File: rtl/pwm_pair_engine.sv
module pwm_pair_engine
  import pwm_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         pol_hi,
  input  logic         center,
  input  logic         tick,
  input  logic [W-1:0] per_buf,
  input  logic [W-1:0] duty_buf,
  output logic         pin,
  output logic [W-1:0] cnt,
  output logic         wrap_evt
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] per_q, duty_q;
  logic         down_q, down_d;
  logic         load;
  logic [W:0]   cnt_inc;
  logic         below_duty;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    load   = 1'b0;
    if (!en) begin
      cnt_d  = '0;
      down_d = 1'b0;
      load   = 1'b1;
    end else if (tick) begin
      if (!center) begin
        down_d = 1'b0;
        if (cnt_inc >= {1'b0, per_q}) begin
          cnt_d = '0;
          load  = 1'b1;
        end else begin
          cnt_d = cnt_inc[W-1:0];
        end
      end else if (per_q == '0) begin
        cnt_d  = '0;
        down_d = 1'b0;
        load   = 1'b1;
      end else if (!down_q && (cnt_q < per_q)) begin
        cnt_d = cnt_inc[W-1:0];
      end else if (cnt_q <= W'(1)) begin
        cnt_d  = '0;
        down_d = 1'b0;
        load   = 1'b1;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        down_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      if (load) begin
        per_q  <= per_buf;
        duty_q <= duty_buf;
      end
    end
  end

  assign below_duty = cnt_q < duty_q;
  assign pin        = en ? pin_level(below_duty, pol_hi) : ~pol_hi;
  assign cnt        = cnt_q;
  assign wrap_evt   = en && tick && load;

  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !center && per_q != '0) |-> cnt_q < per_q); // R2

  AST_CENTER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (en && center) |-> cnt_q <= per_q); // R3

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt_q)); // R5

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0); // R7

  AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (per_q == $past(per_buf)) && (cnt_q == '0)); // R6

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter int CH_W         = 8,
  parameter bit PAIR_PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [ADR_W-1:0] reg_addr,
  input  logic [CH_W-1:0]  reg_wdata,
  output logic [CH_W-1:0]  reg_rdata,
  input  logic             tick_a,
  input  logic             tick_b,
  output logic             pwm_even,
  output logic             pwm_odd
);

  localparam int WIDE_W = 2 * CH_W;
  localparam int N_CH   = 2;

  ctrl_t            ctrl;
  logic             fuse;
  logic [CH_W-1:0]  per_e, per_o, duty_e, duty_o;
  logic [CH_W-1:0]  cnt_e_rd, cnt_o_rd;

  // Narrow channel bundle, index 0 even, 1 odd.
  logic             n_en   [N_CH];
  logic             n_pol  [N_CH];
  logic             n_ctr  [N_CH];
  logic             n_tick [N_CH];
  logic [CH_W-1:0]  n_per  [N_CH];
  logic [CH_W-1:0]  n_duty [N_CH];
  logic             n_pin  [N_CH];
  logic [CH_W-1:0]  n_cnt  [N_CH];
  logic             n_wrap [N_CH];

  logic             w_en, w_tick, w_pin, w_wrap;
  logic [WIDE_W-1:0] w_cnt;

  pwm_pair_regs #(.CH_W(CH_W), .PAIR_PRESENT(PAIR_PRESENT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .cnt_e_rd (cnt_e_rd),
    .cnt_o_rd (cnt_o_rd),
    .rdata    (reg_rdata),
    .ctrl     (ctrl),
    .fuse     (fuse),
    .per_e    (per_e),
    .per_o    (per_o),
    .duty_e   (duty_e),
    .duty_o   (duty_o)
  );

  assign n_en[0]   = ctrl.en_e && !fuse;
  assign n_en[1]   = ctrl.en_o && !fuse;
  assign n_pol[0]  = ctrl.pol_e;
  assign n_pol[1]  = ctrl.pol_o;
  assign n_ctr[0]  = ctrl.ctr_e;
  assign n_ctr[1]  = ctrl.ctr_o;
  assign n_tick[0] = pick_tick(ctrl.sel_e, tick_a, tick_b);
  assign n_tick[1] = pick_tick(ctrl.sel_o, tick_a, tick_b);
  assign n_per[0]  = per_e;
  assign n_per[1]  = per_o;
  assign n_duty[0] = duty_e;
  assign n_duty[1] = duty_o;

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_narrow
      pwm_pair_engine #(.W(CH_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (n_en[i]),
        .pol_hi   (n_pol[i]),
        .center   (n_ctr[i]),
        .tick     (n_tick[i]),
        .per_buf  (n_per[i]),
        .duty_buf (n_duty[i]),
        .pin      (n_pin[i]),
        .cnt      (n_cnt[i]),
        .wrap_evt (n_wrap[i])
      );
    end
  endgenerate

  // Fused channel: odd control bits, even bytes on top.
  assign w_en   = ctrl.en_o && fuse;
  assign w_tick = n_tick[1];

  pwm_pair_engine #(.W(WIDE_W)) u_wide (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (w_en),
    .pol_hi   (ctrl.pol_o),
    .center   (ctrl.ctr_o),
    .tick     (w_tick),
    .per_buf  ({per_e, per_o}),
    .duty_buf ({duty_e, duty_o}),
    .pin      (w_pin),
    .cnt      (w_cnt),
    .wrap_evt (w_wrap)
  );

  assign cnt_e_rd = fuse ? w_cnt[WIDE_W-1:CH_W] : n_cnt[0];
  assign cnt_o_rd = fuse ? w_cnt[CH_W-1:0]      : n_cnt[1];

  assign pwm_even = fuse ? ~ctrl.pol_e : n_pin[0];
  assign pwm_odd  = fuse ? w_pin       : n_pin[1];

  AST_FUSE_PARKS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fuse) && fuse) |-> (n_cnt[0] == '0) && (n_cnt[1] == '0)); // R9

  AST_SPLIT_PARKS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!fuse) && !fuse) |-> w_cnt == '0); // R8

  AST_WRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fuse |-> !(n_wrap[0] || n_wrap[1])); // R9

  AST_WIDE_IDLE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    !fuse |-> !w_wrap); // R8

endmodule

// File: tb/sim_pwm_pair.sv
module sim_pwm_pair;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, rdata1;
  logic       tick_a = 1'b0, tick_b = 1'b0;
  logic       pwm_even, pwm_odd, pe1, po1;

  always #2 clk = ~clk;

  pwm_pair #(.CH_W(8), .PAIR_PRESENT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_a(tick_a),
    .tick_b(tick_b), .pwm_even(pwm_even), .pwm_odd(pwm_odd));

  pwm_pair #(.CH_W(8), .PAIR_PRESENT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .tick_a(tick_a),
    .tick_b(tick_b), .pwm_even(pe1), .pwm_odd(po1));

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench model: 0 even, 1 odd, 2 fused.
  logic [7:0] m_ctrl = '0;
  bit         m_fuse = 0;
  int         b_per[2], b_duty[2];
  int         m_per[3], m_duty[3], m_p[3];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ch_en(input int i);
    if (i == 0) return m_ctrl[0] && !m_fuse;
    if (i == 1) return m_ctrl[1] && !m_fuse;
    return m_ctrl[1] && m_fuse;
  endfunction
  function automatic bit ch_pol(input int i); return (i == 0) ? m_ctrl[2] : m_ctrl[3]; endfunction
  function automatic bit ch_sel(input int i); return (i == 0) ? m_ctrl[4] : m_ctrl[5]; endfunction
  function automatic bit ch_ctr(input int i); return (i == 0) ? m_ctrl[6] : m_ctrl[7]; endfunction

  function automatic void apply(input int i);
    if (i < 2) begin
      m_per[i] = b_per[i];
      m_duty[i] = b_duty[i];
    end else begin
      m_per[2] = b_per[0] * 256 + b_per[1];
      m_duty[2] = b_duty[0] * 256 + b_duty[1];
    end
  endfunction

  function automatic void sync();
    for (int i = 0; i < 3; i++)
      if (!ch_en(i)) begin m_p[i] = 0; apply(i); end
  endfunction

  // Counter value from position within the cycle (R2, R3).
  function automatic int exp_cnt(input int i);
    if (m_per[i] == 0) return 0;
    if (!ch_ctr(i)) return m_p[i];
    return (m_p[i] <= m_per[i]) ? m_p[i] : 2 * m_per[i] - m_p[i];
  endfunction

  function automatic void advance(input int i);
    int len;
    len = ch_ctr(i) ? 2 * m_per[i] : m_per[i];
    m_p[i]++;
    if (m_p[i] >= len) begin m_p[i] = 0; apply(i); end
  endfunction

  function automatic bit exp_pin(input int i);
    if (!ch_en(i)) return !ch_pol(i);
    return (exp_cnt(i) < m_duty[i]) ? ch_pol(i) : !ch_pol(i);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      0: m_ctrl = 8'(d);
      1: m_fuse = d[0];
      2: b_per[0] = d & 255;
      3: b_per[1] = d & 255;
      4: b_duty[0] = d & 255;
      5: b_duty[1] = d & 255;
      default: ;
    endcase
    sync();
  endtask

  task automatic rd(input int a, output int d, output int d1);
    @(negedge clk);
    reg_addr = 3'(a);
    #1;
    d = int'(reg_rdata);
    d1 = int'(rdata1);
  endtask

  task automatic step();
    int r;
    r = $urandom % 4;
    @(negedge clk);
    tick_a = r[0]; tick_b = r[1];
    @(negedge clk);
    tick_a = 1'b0; tick_b = 1'b0;
    for (int i = 0; i < 3; i++)
      if (ch_en(i) && (ch_sel(i) ? r[1] : r[0])) advance(i);
  endtask

  task automatic check_state();
    int ce, co, x;
    if (!m_fuse) begin
      chk(pwm_even == exp_pin(0), "R2/R3/R4/R5 even pin", pwm_even, exp_pin(0));
      chk(pwm_odd == exp_pin(1), "R2/R3/R4/R5 odd pin", pwm_odd, exp_pin(1));
      rd(6, ce, x);
      rd(7, co, x);
      chk(ce == exp_cnt(0), "R6 even counter", ce, exp_cnt(0));
      chk(co == exp_cnt(1), "R6 odd counter", co, exp_cnt(1));
    end else begin
      chk(pwm_even == !m_ctrl[2], "R9 even pin parked", pwm_even, !m_ctrl[2]);
      chk(pwm_odd == exp_pin(2), "R8 fused pin", pwm_odd, exp_pin(2));
      rd(6, ce, x);
      rd(7, co, x);
      chk(ce == (exp_cnt(2) >> 8), "R8 fused high byte", ce, exp_cnt(2) >> 8);
      chk(co == (exp_cnt(2) & 255), "R8 fused low byte", co, exp_cnt(2) & 255);
    end
  endtask

  task automatic run_split();
    int pe, po, x;
    wr(0, 0);
    wr(1, 0);
    pe = 1 + $urandom % 20; po = 1 + $urandom % 20;
    wr(2, pe); wr(3, po);
    wr(4, $urandom % (pe + 3)); wr(5, $urandom % (po + 3));
    wr(0, ($urandom & 8'hFC) | 3);
    check_state();
    for (int k = 0; k < 50; k++) begin step(); check_state(); end
    pe = 1 + $urandom % 20; po = 1 + $urandom % 20;
    wr(2, pe); wr(5, $urandom % (po + 3));
    wr(3, po); wr(4, $urandom % (pe + 3));
    check_state();
    for (int k = 0; k < 70; k++) begin step(); check_state(); end
    wr(0, m_ctrl & 8'hFC);
    rd(6, pe, x);
    rd(7, po, x);
    chk(pe == 0, "R7 even counter cleared", pe, 0);
    chk(po == 0, "R7 odd counter cleared", po, 0);
    chk(pwm_even == !m_ctrl[2], "R4 idle even level", pwm_even, !m_ctrl[2]);
    chk(pwm_odd == !m_ctrl[3], "R4 idle odd level", pwm_odd, !m_ctrl[3]);
  endtask

  task automatic run_fused();
    int p16, d16, n;
    wr(0, 0);
    wr(1, 1);
    p16 = ($urandom % 2) ? 1 + $urandom % 30 : 250 + $urandom % 300;
    d16 = $urandom % (p16 + 3);
    wr(2, p16 >> 8); wr(3, p16 & 255);
    wr(4, d16 >> 8); wr(5, d16 & 255);
    // Even enable set too: it must have no effect (R9).
    wr(0, ($urandom & 8'hFC) | 3);
    check_state();
    n = 2 * p16 + 20;
    if (n > 700) n = 700;
    for (int k = 0; k < n; k++) begin step(); check_state(); end
    p16 = 1 + $urandom % 25;
    wr(2, 0); wr(3, p16); wr(4, 0); wr(5, $urandom % (p16 + 2));
    for (int k = 0; k < 1300; k++) begin step(); check_state(); end
    wr(0, 0);
    wr(1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, v1;
    void'($urandom(32'd4242));
    b_per = '{0, 0}; b_duty = '{0, 0};
    sync();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1/R4 reset state
    rd(0, v, v1);
    chk(v == 0, "R1 control reset", v, 0);
    rd(3, v, v1);
    chk(v == 0, "R1 period reset", v, 0);
    chk(pwm_even == 1'b1, "R4 reset even idle high", pwm_even, 1);
    chk(pwm_odd == 1'b1, "R4 reset odd idle high", pwm_odd, 1);

    // R1 register readback
    for (int a = 2; a < 6; a++) begin
      int d;
      d = $urandom % 256;
      wr(a, d);
      rd(a, v, v1);
      chk(v == d, "R1 buffer readback", v, d);
    end
    wr(0, 8'hA4);
    rd(0, v, v1);
    chk(v == 8'hA4, "R1 control readback", v, 8'hA4);

    // R10: fuse bit absent in u1
    wr(0, 0);
    wr(1, 1);
    rd(1, v, v1);
    chk(v == 1, "R8 fuse bit readback", v, 1);
    chk(v1 == 0, "R10 absent fuse reads zero", v1, 0);
    wr(2, 4); wr(4, 2);
    wr(0, 8'h05);
    chk(pwm_even == 1'b0, "R9 fused even pin inactive", pwm_even, 0);
    chk(pe1 == 1'b1, "R10 absent fuse keeps even channel", pe1, 1);
    wr(0, 0);
    wr(1, 0);

    // R5 directed: unselected enable ignored
    wr(3, 10); wr(5, 3);
    wr(0, 8'h22);
    repeat (3) begin
      @(negedge clk); tick_a = 1'b1;
      @(negedge clk); tick_a = 1'b0;
    end
    rd(7, v, v1);
    chk(v == 0, "R5 tick_a ignored when select 1", v, 0);
    @(negedge clk); tick_b = 1'b1;
    @(negedge clk); tick_b = 1'b0;
    rd(7, v, v1);
    chk(v == 1, "R5 tick_b advances", v, 1);
    wr(0, 0);

    for (int t = 0; t < 24; t++) run_split();
    for (int t = 0; t < 6; t++) run_fused();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule